// File: doc/BRIEF.md
# OTP Boot Patch Loader

This block runs once per request, normally just after reset, to pull an optional boot patch out of a 16 KiB one-time-programmable array and place it in SRAM. It reads the array through a byte-wide synchronous port that returns data one cycle after the address is presented. The first six bytes form a header: a four-byte signature and a two-byte little-endian byte count. When the signature is correct, the counted bytes that follow the header are streamed into a byte-write SRAM port at a fixed vector address, one byte per cycle.

When it finishes, the block holds `done` high and reports one of four outcomes. With a patch, `patch_valid` and `jump_req` are both high, and the boot sequencer branches to the vector. With a valid but empty patch, `patch_valid` is high and there is no jump. With a bad signature, neither flag is set. With a count that runs past the end of the array, `error` is set and nothing is written. These outcomes stay on the outputs until the next `start`.

Top module: `patch_loader`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `error`, `patch_valid`, `jump_req`, `sram_we` and `otp_rd_en` are all low until `start` is seen.
- R2: A `start` pulse while idle or finished raises `busy` on the next cycle. Reads are then issued one per cycle at consecutive ascending addresses, beginning at OTP address 0.
- R3: The bytes at OTP addresses 0, 1, 2 and 3 must read 0x52, 0x4F, 0x58 and 0x4D, the word 0x4D584F52 stored little-endian. On any mismatch the block ends with `done`=1 and `patch_valid`, `jump_req` and `error` all 0. It makes no SRAM write and reads nothing above address 5.
- R4: The patch length is byte 4 plus 256 times byte 5. Patch byte i, read from OTP address 6+i, is written to SRAM address 0x805F8000+i in ascending order. Each write occurs two cycles after its read was issued, which is the cycle after its data returns.
- R5: After the last patch byte is written, `busy` drops and `done`, `patch_valid` and `jump_req` are all 1 with `error`=0.
- R6: A length of zero ends with `done`=1, `patch_valid`=1, `jump_req`=0 and no SRAM write.
- R7: If 6 plus the length exceeds 16384, the block ends with `done`=1, `error`=1, `patch_valid`=0 and `jump_req`=0. It makes no SRAM write and reads nothing above address 5. A length of 16378, which ends exactly at address 0x3FFF, is accepted and copied in full.
- R8: `start` is ignored while `busy` is high. The write sequence and its outcome are unchanged.
- R9: The final outcome holds until the next `start`. A new `start` clears the outcome flags and begins a fresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a load (ignored while busy) |
| otp_rd_en | output | 1 | OTP read strobe |
| otp_addr | output | 14 | OTP byte address |
| otp_rd_data | input | 8 | OTP read data, valid the cycle after the strobe |
| sram_we | output | 1 | SRAM byte write enable |
| sram_addr | output | 32 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Load finished, with any outcome |
| patch_valid | output | 1 | Signature accepted and length in range |
| jump_req | output | 1 | Request to branch to the copied patch |
| error | output | 1 | Length runs past the end of the OTP |

## Verification
The bench tests signatures that differ in one bit and signatures with their byte order reversed. A loader that compared the signature big-endian, or checked only part of it, would copy junk and request a jump. It also covers lengths of zero, one, one past the limit, 0xFFFF, and exactly the maximum of 16378. An off-by-one in the range check would either reject the final legal byte at 0x3FFF or wrap the address and start writing. A 300-byte length exercises the upper length byte, which a byte-swapped length would get wrong. `start` pulses in the middle of a copy catch a design that restarts or truncates. The first-write latency check catches a design whose data pairs with the wrong address.

// File: rtl/patch_loader_pkg.sv
package patch_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAGIC,
    ST_LEN,
    ST_COPY,
    ST_DONE,
    ST_ERR
  } ld_state_e;

  localparam int unsigned MAGIC_BYTES = 4;

endpackage

// File: rtl/pl_rst_sync.sv
module pl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n = sync_q[1];

endmodule

// File: rtl/pl_header.sv
module pl_header
  import patch_loader_pkg::*;
#(
  parameter int          PTR_W      = 17,
  parameter int          LEN_W      = 16,
  parameter logic [31:0] MAGIC_WORD = 32'h4D584F52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rsp_vld,
  input  logic [PTR_W-1:0] rsp_addr,
  input  logic [7:0]       rsp_data,
  output logic             magic_bad,
  output logic [LEN_W-1:0] hdr_len
);

  localparam int LEN_BYTES = LEN_W / 8;

  logic [7:0] exp_byte;
  logic       sig_byte;
  logic       miss_now;
  logic       bad_q;

  always_comb begin
    exp_byte = MAGIC_WORD[{rsp_addr[1:0], 3'b000} +: 8];
    sig_byte = rsp_addr < PTR_W'(MAGIC_BYTES);
    miss_now = rsp_vld && sig_byte && (rsp_data != exp_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q <= 1'b0;
    end else if (clear) begin
      bad_q <= 1'b0;
    end else if (miss_now) begin
      bad_q <= 1'b1;
    end
  end

  assign magic_bad = bad_q | miss_now;

  for (genvar k = 0; k < LEN_BYTES; k++) begin : g_len
    localparam logic [PTR_W-1:0] POS = PTR_W'(MAGIC_BYTES + k);
    logic       hit;
    logic [7:0] byte_q;

    assign hit = rsp_vld && (rsp_addr == POS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (hit) begin
        byte_q <= rsp_data;
      end
    end

    assign hdr_len[8*k +: 8] = hit ? rsp_data : byte_q;
  end

  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q && !clear |=> bad_q); // R3

endmodule

// File: rtl/pl_ctrl.sv
module pl_ctrl
  import patch_loader_pkg::*;
#(
  parameter int OTP_AW   = 14,
  parameter int OTP_SIZE = 16384,
  parameter int LEN_W    = 16,
  parameter int HDR      = 6,
  parameter int PTR_W    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              magic_bad,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              wr_last,
  output logic              otp_rd_en,
  output logic [OTP_AW-1:0] otp_addr,
  output logic              rsp_vld,
  output logic [PTR_W-1:0]  rsp_addr,
  output logic              hdr_clear,
  output logic              copy_rsp,
  output logic              copy_last,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic              patch_valid,
  output logic              jump_req
);

  ld_state_e        state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] end_q, end_d;
  logic             valid_q, valid_d;
  logic             jump_q, jump_d;
  logic             rsp_vld_q;
  logic [PTR_W-1:0] rsp_addr_q;
  logic [PTR_W-1:0] len_ext;
  logic [PTR_W-1:0] total;
  logic             rd_en;

  always_comb begin
    state_d   = state_q;
    ptr_d     = ptr_q;
    end_d     = end_q;
    valid_d   = valid_q;
    jump_d    = jump_q;
    rd_en     = 1'b0;
    hdr_clear = 1'b0;
    len_ext   = PTR_W'(hdr_len);
    total     = PTR_W'(HDR) + len_ext;
    case (state_q)
      ST_IDLE, ST_DONE, ST_ERR: begin
        if (start) begin
          state_d   = ST_MAGIC;
          ptr_d     = '0;
          valid_d   = 1'b0;
          jump_d    = 1'b0;
          hdr_clear = 1'b1;
        end
      end
      ST_MAGIC: begin
        rd_en = ptr_q < PTR_W'(HDR);
        if (rsp_vld_q && rsp_addr_q == PTR_W'(MAGIC_BYTES - 1)) begin
          state_d = magic_bad ? ST_DONE : ST_LEN;
        end
      end
      ST_LEN: begin
        rd_en = ptr_q < PTR_W'(HDR);
        if (rsp_vld_q && rsp_addr_q == PTR_W'(HDR - 1)) begin
          if (total > PTR_W'(OTP_SIZE)) begin
            state_d = ST_ERR;
          end else if (len_ext == '0) begin
            state_d = ST_DONE;
            valid_d = 1'b1;
          end else begin
            state_d = ST_COPY;
            end_d   = total;
            valid_d = 1'b1;
            jump_d  = 1'b1;
          end
        end
      end
      ST_COPY: begin
        rd_en = ptr_q < end_q;
        if (wr_last) begin
          state_d = ST_DONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (rd_en) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      end_q      <= '0;
      valid_q    <= 1'b0;
      jump_q     <= 1'b0;
      rsp_vld_q  <= 1'b0;
      rsp_addr_q <= '0;
    end else begin
      state_q   <= state_d;
      ptr_q     <= ptr_d;
      end_q     <= end_d;
      valid_q   <= valid_d;
      jump_q    <= jump_d;
      rsp_vld_q <= rd_en;
      if (rd_en) begin
        rsp_addr_q <= ptr_q;
      end
    end
  end

  assign otp_rd_en   = rd_en;
  assign otp_addr    = ptr_q[OTP_AW-1:0];
  assign rsp_vld     = rsp_vld_q;
  assign rsp_addr    = rsp_addr_q;
  assign copy_rsp    = rsp_vld_q && (state_q == ST_COPY);
  assign copy_last   = copy_rsp && (rsp_addr_q == end_q - 1'b1);
  assign busy        = (state_q == ST_MAGIC) || (state_q == ST_LEN) || (state_q == ST_COPY);
  assign done        = (state_q == ST_DONE) || (state_q == ST_ERR);
  assign error       = (state_q == ST_ERR);
  assign patch_valid = (state_q == ST_DONE) && valid_q;
  assign jump_req    = (state_q == ST_DONE) && jump_q;

  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    otp_rd_en |-> busy); // R2
  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    otp_rd_en && $past(otp_rd_en) |-> otp_addr == $past(otp_addr) + 1'b1); // R2
  AST_JUMP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    jump_req |-> patch_valid && done); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !patch_valid && !jump_req); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !wr_last && !(rsp_vld && rsp_addr < PTR_W'(HDR)) |=> busy); // R8

endmodule

// File: rtl/pl_sram_wr.sv
module pl_sram_wr #(
  parameter int          PTR_W     = 17,
  parameter int          SRAM_AW   = 32,
  parameter int          HDR       = 6,
  parameter logic [31:0] SRAM_BASE = 32'h805F8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               copy_rsp,
  input  logic               copy_last,
  input  logic [PTR_W-1:0]   rsp_addr,
  input  logic [7:0]         rsp_data,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               wr_last
);

  logic [PTR_W-1:0]   offset;
  logic               we_q;
  logic               last_q;
  logic [SRAM_AW-1:0] addr_q;
  logic [7:0]         data_q;

  assign offset = rsp_addr - PTR_W'(HDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      last_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q   <= copy_rsp;
      last_q <= copy_last;
      if (copy_rsp) begin
        addr_q <= SRAM_AW'(SRAM_BASE) + SRAM_AW'(offset);
        data_q <= rsp_data;
      end
    end
  end

  assign sram_we    = we_q;
  assign sram_addr  = addr_q;
  assign sram_wdata = data_q;
  assign wr_last    = we_q && last_q;

  AST_WR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we && $past(sram_we) |-> sram_addr == $past(sram_addr) + 1'b1); // R4

endmodule

// File: rtl/patch_loader.sv
module patch_loader #(
  parameter int          OTP_AW     = 14,
  parameter int          LEN_W      = 16,
  parameter int          SRAM_AW    = 32,
  parameter logic [31:0] SRAM_BASE  = 32'h805F8000,
  parameter logic [31:0] MAGIC_WORD = 32'h4D584F52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               otp_rd_en,
  output logic [OTP_AW-1:0]  otp_addr,
  input  logic [7:0]         otp_rd_data,
  output logic               sram_we,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic [7:0]         sram_wdata,
  output logic               busy,
  output logic               done,
  output logic               patch_valid,
  output logic               jump_req,
  output logic               error
);

  localparam int OTP_SIZE = 1 << OTP_AW;
  localparam int HDR      = patch_loader_pkg::MAGIC_BYTES + LEN_W / 8;
  localparam int PTR_W    = (LEN_W > OTP_AW) ? LEN_W + 1 : OTP_AW + 1;

  logic             rst_n_s;
  logic             magic_bad;
  logic [LEN_W-1:0] hdr_len;
  logic             wr_last;
  logic             rsp_vld;
  logic [PTR_W-1:0] rsp_addr;
  logic             hdr_clear;
  logic             copy_rsp;
  logic             copy_last;

  pl_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_n_s)
  );

  pl_ctrl #(
    .OTP_AW   (OTP_AW),
    .OTP_SIZE (OTP_SIZE),
    .LEN_W    (LEN_W),
    .HDR      (HDR),
    .PTR_W    (PTR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .magic_bad   (magic_bad),
    .hdr_len     (hdr_len),
    .wr_last     (wr_last),
    .otp_rd_en   (otp_rd_en),
    .otp_addr    (otp_addr),
    .rsp_vld     (rsp_vld),
    .rsp_addr    (rsp_addr),
    .hdr_clear   (hdr_clear),
    .copy_rsp    (copy_rsp),
    .copy_last   (copy_last),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .patch_valid (patch_valid),
    .jump_req    (jump_req)
  );

  pl_header #(
    .PTR_W      (PTR_W),
    .LEN_W      (LEN_W),
    .MAGIC_WORD (MAGIC_WORD)
  ) u_header (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clear     (hdr_clear),
    .rsp_vld   (rsp_vld),
    .rsp_addr  (rsp_addr),
    .rsp_data  (otp_rd_data),
    .magic_bad (magic_bad),
    .hdr_len   (hdr_len)
  );

  pl_sram_wr #(
    .PTR_W     (PTR_W),
    .SRAM_AW   (SRAM_AW),
    .HDR       (HDR),
    .SRAM_BASE (SRAM_BASE)
  ) u_sram_wr (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .copy_rsp   (copy_rsp),
    .copy_last  (copy_last),
    .rsp_addr   (rsp_addr),
    .rsp_data   (otp_rd_data),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata),
    .wr_last    (wr_last)
  );

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    error |-> !sram_we); // R7
  AST_NO_WRITE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !sram_we && !otp_rd_en); // R5

endmodule

// File: tb/patch_loader_bench.sv
`timescale 1ns/1ps
module patch_loader_bench;

  localparam logic [31:0] BASE = 32'h805F8000;
  localparam logic [31:0] GOOD = 32'h4D584F52;

  typedef struct packed {
    logic [31:0] magic;
    logic [15:0] len;
    logic [7:0]  seed;
    logic        exp_err;
    logic        exp_valid;
    logic        exp_jump;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{GOOD,          16'd5,     8'h11, 1'b0, 1'b1, 1'b1},
    '{GOOD,          16'd1,     8'h22, 1'b0, 1'b1, 1'b1},
    '{GOOD,          16'd0,     8'h33, 1'b0, 1'b1, 1'b0},
    '{32'h4D584F53,  16'd5,     8'h44, 1'b0, 1'b0, 1'b0},
    '{32'h524F584D,  16'd5,     8'h55, 1'b0, 1'b0, 1'b0},
    '{GOOD,          16'd16379, 8'h66, 1'b1, 1'b0, 1'b0},
    '{GOOD,          16'hFFFF,  8'h77, 1'b1, 1'b0, 1'b0},
    '{GOOD,          16'd300,   8'h5A, 1'b0, 1'b1, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        otp_rd_en;
  logic [13:0] otp_addr;
  logic [7:0]  otp_rd_data;
  logic        sram_we;
  logic [31:0] sram_addr;
  logic [7:0]  sram_wdata;
  logic        busy, done, patch_valid, jump_req, error;

  logic [31:0] h_magic;
  logic [15:0] h_len;
  logic [7:0]  h_seed;

  int checks, fails, cyc;
  int wcount, rd_cnt, max_rd, rd6_cyc, wr0_cyc;
  bit data_bad, rd_bad, last_rd_valid;
  logic [13:0] last_rd;

  patch_loader u_patch_loader (
    .clk (clk), .rst_n (rst_n), .start (start),
    .otp_rd_en (otp_rd_en), .otp_addr (otp_addr), .otp_rd_data (otp_rd_data),
    .sram_we (sram_we), .sram_addr (sram_addr), .sram_wdata (sram_wdata),
    .busy (busy), .done (done), .patch_valid (patch_valid),
    .jump_req (jump_req), .error (error)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] otp_byte(logic [13:0] a);
    case (a)
      14'd0: return h_magic[7:0];
      14'd1: return h_magic[15:8];
      14'd2: return h_magic[23:16];
      14'd3: return h_magic[31:24];
      14'd4: return h_len[7:0];
      14'd5: return h_len[15:8];
      default: return a[7:0] ^ {a[13:8], 2'b01} ^ h_seed;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (otp_rd_en) otp_rd_data <= otp_byte(otp_addr);
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "R2", "watchdog expired", cyc, 150000);
      finish_run();
    end
    if (otp_rd_en) begin
      if (last_rd_valid ? (otp_addr != last_rd + 14'd1) : (otp_addr != 14'd0)) rd_bad = 1'b1;
      last_rd = otp_addr;
      last_rd_valid = 1'b1;
      rd_cnt++;
      if (int'(otp_addr) > max_rd) max_rd = int'(otp_addr);
      if (otp_addr == 14'd6) rd6_cyc = cyc;
    end
    if (sram_we) begin
      if (wcount == 0) wr0_cyc = cyc;
      if (sram_addr != BASE + 32'(wcount) ||
          sram_wdata != otp_byte(14'(6 + wcount))) data_bad = 1'b1;
      wcount++;
    end
  end

  task automatic pulse_start();
    @(negedge clk);
    wcount = 0; rd_cnt = 0; max_rd = -1; data_bad = 0; rd_bad = 0;
    last_rd_valid = 0; rd6_cyc = -1; wr0_cyc = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 70000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_case(vec_t v, string tag);
    int exp_w;
    h_magic = v.magic; h_len = v.len; h_seed = v.seed;
    exp_w = v.exp_jump ? int'(v.len) : 0;
    pulse_start();
    check(busy && !done, "R2", {tag, " busy after start"}, busy, 1);
    wait_done();
    check(done && !busy, "R5", {tag, " done"}, {busy, done}, 2'b01);
    check(error == v.exp_err, v.exp_err ? "R7" : "R3", {tag, " error"}, error, v.exp_err);
    check(patch_valid == v.exp_valid, v.exp_valid ? "R5" : "R3", {tag, " patch_valid"}, patch_valid, v.exp_valid);
    check(jump_req == v.exp_jump, (v.len == 0) ? "R6" : "R5", {tag, " jump_req"}, jump_req, v.exp_jump);
    check(wcount == exp_w, "R4", {tag, " write count"}, wcount, exp_w);
    check(!data_bad, "R4", {tag, " write addr/data"}, data_bad, 0);
    check(!rd_bad, "R2", {tag, " read order"}, rd_bad, 0);
    if (!v.exp_valid || v.exp_err)
      check(max_rd <= 5, v.exp_err ? "R7" : "R3", {tag, " no read past header"}, max_rd, 5);
    if (exp_w > 0)
      check(wr0_cyc == rd6_cyc + 2, "R4", {tag, " write latency"}, wr0_cyc - rd6_cyc, 2);
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0;
    start = 1'b0; rst_n = 1'b0;
    h_magic = GOOD; h_len = 16'd0; h_seed = 8'h00;
    repeat (3) @(negedge clk);
    check({busy, done, error, patch_valid, jump_req, sram_we, otp_rd_en} == 7'b0,
          "R1", "outputs in reset", {busy, done, error, patch_valid, jump_req, sram_we, otp_rd_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check({busy, done, error, patch_valid, jump_req, sram_we, otp_rd_en} == 7'b0,
          "R1", "outputs after reset", {busy, done, error, patch_valid, jump_req, sram_we, otp_rd_en}, 0);

    for (int i = 0; i < NV; i++) begin
      run_case(VECS[i], $sformatf("vec%0d", i));
    end

    // R7 boundary: largest legal length ends at 0x3FFF
    run_case('{GOOD, 16'd16378, 8'h3C, 1'b0, 1'b1, 1'b1}, "max_len");

    // R8: start pulses mid-copy are ignored
    h_magic = GOOD; h_len = 16'd20; h_seed = 8'h99;
    pulse_start();
    repeat (10) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check(wcount == 20, "R8", "writes with start while busy", wcount, 20);
    check(!data_bad && patch_valid && jump_req, "R8", "outcome with start while busy",
          {data_bad, patch_valid, jump_req}, 3'b011);

    // R9: outcome holds, then restart clears it
    repeat (12) @(negedge clk);
    check(done && patch_valid && jump_req && !busy, "R9", "outcome held",
          {done, patch_valid, jump_req, busy}, 4'b1110);
    h_magic = 32'h00000000;
    pulse_start();
    check(!done && !patch_valid && !jump_req, "R9", "restart clears outcome",
          {done, patch_valid, jump_req}, 0);
    wait_done();
    check(done && !patch_valid && wcount == 0, "R9", "restart bad magic result",
          {done, patch_valid}, 2'b10);

    finish_run();
  end

endmodule